// File: doc/BRIEF.md
# Modal Bus Driver

A 16-bit one-way bus driver that carries an input word to an output word through one storage element per bit. A single mode input decides how that element behaves. With the mode input low, the element is see-through and the output tracks the input. With it high, the element loads the input only on a rising clock edge and holds its value at every other time.

An active-low output enable decides whether the bus is driven. Rather than a real three-state pin, the block exports the data word together with a per-bit drive-enable word, and the chip's pad ring turns the pair into a three-state pad. Each input bit has a keeper stage: while a bit's line is reported as undriven, the keeper feeds the storage stage the last level seen while the line was driven.

The asynchronous reset input is synchronised to the clock before it reaches any storage.

Top module: `modal_bus_driver`

## Requirements
- R1: While reset is asserted, the stored word is 0 and y_dat reads 0x0000. With oe_n high, y_en reads 0x0000.
- R2: With oe_n high, every y_en bit is 0 whatever le, clk and a do. With oe_n low, every y_en bit is 1. In both cases y_dat carries the value held in storage.
- R3: With le low, y_dat equals the keeper-filtered input in the same cycle, and rising clock edges have no additional effect.
- R4: With le high, each rising clk edge loads the keeper-filtered input, and y_dat shows the loaded word from that edge on.
- R5: With le high and clk held steady, either high or low, y_dat keeps its value while a changes.
- R6: When le rises, y_dat keeps the last value passed in see-through mode, even if a changes, until the next rising clk edge.
- R7: A bit whose a_drv bit is 0 is treated as undriven. The storage element receives the last value of that a bit seen while its a_drv bit was 1, in either mode. After reset, that value is 0.
- R8: Toggling oe_n never changes the stored word. y_dat is unchanged across any change of oe_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Load clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oe_n | input | 1 | Output enable, active low |
| le | input | 1 | Mode select: 0 see-through, 1 edge-loaded |
| a | input | 16 | Input data bus |
| a_drv | input | 16 | Per-bit flag, 1 when the input line is driven |
| y_dat | output | 16 | Output data word |
| y_en | output | 16 | Per-bit pad drive enable, 1 drives y_dat onto the bus |

## Verification
The bench targets several corner cases.

- The input changes just after le rises with no clock edge. A design that loads on the le edge, or stays see-through, would show the new input instead of the last passed word.
- The input changes while clk is held high. A level-sensitive design would follow it.
- oe_n toggles while data is stored. A design that clears or reloads storage on enable would corrupt y_dat.
- Bits are marked undriven, partly and then fully, across both modes. A keeper that latched the wrong level, or no keeper at all, would pass the junk input through.

// File: rtl/mbd_pkg.sv
`timescale 1ns/1ps
package mbd_pkg;
  // which storage path feeds the output in edge-loaded mode
  typedef enum logic {
    SRC_LATCH = 1'b0,
    SRC_FLOP  = 1'b1
  } src_e;
endpackage

// File: rtl/mbd_rst_sync.sv
`timescale 1ns/1ps
module mbd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;
  logic s1_d, s2_d;

  always_comb begin
    s1_d = 1'b1;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/mbd_keeper.sv
`timescale 1ns/1ps
module mbd_keeper (
  input  logic clk,
  input  logic rst_n,
  input  logic drv,
  input  logic d,
  output logic q
);
  logic held;

  // level keeper: follows the line while driven, freezes otherwise
  always_latch begin
    if (!rst_n)   held = 1'b0;
    else if (drv) held = d;
  end

  assign q = drv ? d : held;

  AST_KEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv && $past(!drv)) |-> $stable(q)); // R7
endmodule

// File: rtl/mbd_store.sv
`timescale 1ns/1ps
module mbd_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import mbd_pkg::*;

  logic [W-1:0] lat_q;
  logic         lat_tag;
  logic [W-1:0] ff_q, ff_q_nxt;
  logic         ff_tag, ff_tag_nxt;
  logic         edge_seen;
  src_e         src;

  // see-through path; snapshots the flop tag so a fresh edge can be told apart
  always_latch begin
    if (!rst_n) begin
      lat_q   = '0;
      lat_tag = 1'b0;
    end else if (!le) begin
      lat_q   = d;
      lat_tag = ff_tag;
    end
  end

  // edge path, clock enable written out as le
  always_comb begin
    ff_q_nxt   = ff_q;
    ff_tag_nxt = ff_tag;
    if (le) begin
      ff_q_nxt   = d;
      ff_tag_nxt = ~lat_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q   <= '0;
      ff_tag <= 1'b0;
    end else begin
      ff_q   <= ff_q_nxt;
      ff_tag <= ff_tag_nxt;
    end
  end

  assign edge_seen = ff_tag ^ lat_tag;
  assign src       = edge_seen ? SRC_FLOP : SRC_LATCH;
  assign q         = (src == SRC_FLOP) ? ff_q : lat_q;

  AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !le |-> (q == d)); // R3
  AST_EDGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (edge_seen -> (q == $past(d)))); // R4
  AST_NO_EARLY_FLOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!le) |-> !edge_seen); // R6
endmodule

// File: rtl/mbd_drive.sv
`timescale 1ns/1ps
module mbd_drive #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] y_dat,
  output logic [W-1:0] y_en
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pad
      assign y_en[i]  = ~oe_n;
      assign y_dat[i] = d[i];
    end
  endgenerate

  AST_EN_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(y_en) == 0) || ($countones(y_en) == W)); // R2
endmodule

// File: rtl/modal_bus_driver.sv
`timescale 1ns/1ps
module modal_bus_driver #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             le,
  input  logic [BUS_W-1:0] a,
  input  logic [BUS_W-1:0] a_drv,
  output logic [BUS_W-1:0] y_dat,
  output logic [BUS_W-1:0] y_en
);
  localparam int MSB = BUS_W - 1;

  logic           rst_sync_n;
  logic [MSB:0]   a_clean;
  logic [MSB:0]   stored;

  mbd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  genvar b;
  generate
    for (b = 0; b < BUS_W; b++) begin : g_keep
      mbd_keeper u_keep (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .drv   (a_drv[b]),
        .d     (a[b]),
        .q     (a_clean[b])
      );
    end
  endgenerate

  mbd_store #(.W(BUS_W)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .le    (le),
    .d     (a_clean),
    .q     (stored)
  );

  mbd_drive #(.W(BUS_W)) u_drive (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .oe_n  (oe_n),
    .d     (stored),
    .y_dat (y_dat),
    .y_en  (y_en)
  );
endmodule

// File: tb/sim_modal_bus_driver.sv
`timescale 1ns/1ps
module sim_modal_bus_driver;
  logic        clk, rst_n, oe_n, le;
  logic [15:0] a, a_drv;
  logic [15:0] y_dat, y_en;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  modal_bus_driver u0 (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .le(le),
    .a(a), .a_drv(a_drv), .y_dat(y_dat), .y_en(y_en)
  );

  // {oe_n, le, pulse, a, expected y_dat, expected y_en}
  localparam logic [50:0] VEC [9] = '{
    {1'b0, 1'b0, 1'b0, 16'hA5A5, 16'hA5A5, 16'hFFFF}, // R3 R2
    {1'b0, 1'b0, 1'b0, 16'h5A5A, 16'h5A5A, 16'hFFFF}, // R3
    {1'b1, 1'b0, 1'b0, 16'h1234, 16'h1234, 16'h0000}, // R2
    {1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h1234, 16'hFFFF}, // R6
    {1'b0, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R4
    {1'b0, 1'b1, 1'b0, 16'h0000, 16'hFFFF, 16'hFFFF}, // R5
    {1'b1, 1'b1, 1'b1, 16'h0F0F, 16'h0F0F, 16'h0000}, // R4 R2
    {1'b0, 1'b1, 1'b0, 16'hF0F0, 16'h0F0F, 16'hFFFF}, // R8
    {1'b0, 1'b0, 1'b0, 16'hF0F0, 16'hF0F0, 16'hFFFF}  // R3
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse();
    clk = 1'b1; #2.5;
    clk = 1'b0; #2.5;
  endtask

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    clk = 0; rst_n = 0; oe_n = 1; le = 1; a = '0; a_drv = 16'hFFFF;
    pulse(); pulse();
    chk("R1 y_dat in reset", y_dat, 16'h0000);
    chk("R1 y_en in reset", y_en, 16'h0000);
    rst_n = 1;
    pulse(); pulse(); pulse();
    chk("R1 y_dat after release", y_dat, 16'h0000);

    for (int i = 0; i < 9; i++) begin
      oe_n = VEC[i][50];
      le   = VEC[i][49];
      #0.5;
      a = VEC[i][47:32];
      #1;
      if (VEC[i][48]) begin
        clk = 1'b1; #2.5; clk = 1'b0; #1;
      end
      chk($sformatf("vec%0d y_dat", i), y_dat, VEC[i][31:16]);
      chk($sformatf("vec%0d y_en", i), y_en, VEC[i][15:0]);
      #2;
    end

    // R5: clk held high, input moves
    le = 1; #0.5; a = 16'h3C3C; #1;
    clk = 1; #2.5;
    chk("R4 load before high hold", y_dat, 16'h3C3C);
    a = 16'hC3C3; #1;
    chk("R5 clk held high", y_dat, 16'h3C3C);
    clk = 0; #1;
    chk("R5 clk back low", y_dat, 16'h3C3C);

    // R8: enable toggling leaves storage alone
    oe_n = 1; #1;
    chk("R8 disabled data", y_dat, 16'h3C3C);
    chk("R2 disabled enables", y_en, 16'h0000);
    oe_n = 0; #1; oe_n = 1; #1; oe_n = 0; #1;
    chk("R8 after toggles", y_dat, 16'h3C3C);
    chk("R2 enabled enables", y_en, 16'hFFFF);

    // R3 clock has no effect in see-through mode; R6 again
    le = 0; #0.5; a = 16'h1111; #1;
    pulse();
    chk("R3 edge in pass mode", y_dat, 16'h1111);
    le = 1; #0.5; a = 16'h2222; #1;
    chk("R6 le rise holds passed", y_dat, 16'h1111);
    pulse();
    chk("R4 load after le rise", y_dat, 16'h2222);

    // R7 keeper
    le = 0; #0.5; a = 16'hAAAA; #1;
    chk("R3 pass before float", y_dat, 16'hAAAA);
    a_drv = 16'h00FF; a = 16'h5555; #1;
    chk("R7 upper byte floats", y_dat, 16'hAA55);
    pulse();
    a_drv = 16'h0000; a = 16'h0000; #1;
    chk("R7 all float pass mode", y_dat, 16'hAA55);
    pulse();
    le = 1; #0.5; a = 16'hFFFF; #1;
    pulse();
    chk("R7 all float edge mode", y_dat, 16'hAA55);
    a_drv = 16'hFFFF; a = 16'h0000; #1;
    pulse();
    chk("R4 redriven load", y_dat, 16'h0000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule